// File: doc/BRIEF.md
# Translation lookaside buffer

This block holds a small set of recent page-to-frame mappings and searches all of them at once. A lookup presents a virtual page number and a page offset. When a valid stored page number equals the request, the block reports a hit and returns the stored frame number in the same cycle. It also returns the physical address, built from that frame number and the offset.

When no valid entry matches, the block reports a miss. The frame number must then be fetched from the page table held in memory. Walking that table is done outside this block. The walker later writes the result back through the fill port, which carries the page number, the frame number and the page-table valid bit.

Fills go to a free slot first. When every slot is occupied, a fill replaces the least recently used entry, and the recency order is kept exactly. A flush input drops every mapping at once, for use on a process switch.

Top module: `tlb`

## Requirements
- R1: When `lk_valid_i` is high and a valid entry holds `lk_vpn_i`, `lk_hit_o` is 1 in the same cycle. In that case `lk_pfn_o` is the stored frame number and `lk_paddr_o` equals `{lk_pfn_o, lk_off_i}`, with the frame number in the upper bits and the offset in the low `OFF_W` bits.
- R2: When `lk_valid_i` is high and no valid entry holds `lk_vpn_i`, `lk_miss_o` is 1 and `lk_hit_o` is 0. When `lk_valid_i` is low, both outputs are 0. The two outputs are never high together.
- R3: A fill with `fill_pte_valid_i` = 0 stores an entry that never produces a hit. If that fill names a page that is already present, that page stops hitting from the next cycle on.
- R4: A fill whose page is not already present, made while at least one slot is invalid, goes to the invalid slot with the lowest index. No valid mapping is displaced.
- R5: A fill whose page is not present, made while all slots are valid, replaces the least recently used entry. A lookup hit and a fill each make their entry the most recently used. A lookup miss and a flush leave the recency order unchanged. After reset, the recency order from most to least recent is slot 0 up to slot ENTRIES-1.
- R6: A fill whose page number already sits in a valid entry overwrites that entry's frame number and valid bit. No second copy is created, and the new frame number is returned from the next cycle on.
- R7: `flush_i` clears every valid flag at the next clock edge, so every lookup after it misses. If a fill arrives in the same cycle as a flush, the flush wins and the fill is dropped.
- R8: After reset, every entry is invalid and every lookup misses.
- R9: At no time do two valid entries hold the same page number.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| flush_i | input | 1 | Invalidate all entries |
| lk_valid_i | input | 1 | Lookup request |
| lk_vpn_i | input | VPN_W | Virtual page number to translate |
| lk_off_i | input | OFF_W | Page offset of the access |
| lk_hit_o | output | 1 | Valid mapping found |
| lk_miss_o | output | 1 | No valid mapping; the frame number must come from the page table |
| lk_pfn_o | output | PFN_W | Frame number on a hit, 0 otherwise |
| lk_paddr_o | output | PFN_W+OFF_W | Frame number joined with the offset |
| fill_i | input | 1 | Write a mapping |
| fill_vpn_i | input | VPN_W | Page number to store |
| fill_pfn_i | input | PFN_W | Frame number to store |
| fill_pte_valid_i | input | 1 | Page-table valid bit stored with the mapping |

## Verification
The assertions assume that a lookup and a fill are not presented in the same cycle, because the recency update then gives the fill priority. The stimulus never raises `lk_valid_i` together with `fill_i` or `flush_i`. The only exception is one deliberate case where a flush and a fill coincide, which tests the priority rule. Page numbers are drawn from a range twice the entry count, so that hits, misses, duplicate fills and evictions all occur often.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  typedef enum logic [1:0] {
    TGT_HIT  = 2'd0,
    TGT_FREE = 2'd1,
    TGT_LRU  = 2'd2
  } fill_tgt_e;
endpackage

// File: rtl/tlb_cam.sv
module tlb_cam #(
  parameter int unsigned ENTRIES = 16,
  parameter int unsigned VPN_W   = 20
) (
  input  logic [ENTRIES-1:0]            valid_i,
  input  logic [ENTRIES-1:0][VPN_W-1:0] tag_i,
  input  logic [VPN_W-1:0]              key_i,
  output logic [ENTRIES-1:0]            match_o
);
  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    assign match_o[g] = valid_i[g] && (tag_i[g] == key_i);
  end
endmodule

// File: rtl/tlb_lru.sv
module tlb_lru #(
  parameter int unsigned ENTRIES = 16,
  localparam int unsigned IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             touch_i,
  input  logic [IDX_W-1:0] touch_idx_i,
  output logic [IDX_W-1:0] victim_o
);
  // age 0 = most recent, ENTRIES-1 = least recent; ages form a permutation
  logic [ENTRIES-1:0][IDX_W-1:0] age_q;
  logic [ENTRIES-1:0]            oldest;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < ENTRIES; i++) age_q[i] <= IDX_W'(i);
    end else if (touch_i) begin
      for (int i = 0; i < ENTRIES; i++) begin
        if (IDX_W'(i) == touch_idx_i)           age_q[i] <= '0;
        else if (age_q[i] < age_q[touch_idx_i]) age_q[i] <= age_q[i] + 1'b1;
      end
    end
  end

  always_comb begin
    victim_o = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      oldest[i] = (age_q[i] == IDX_W'(ENTRIES - 1));
      if (oldest[i]) victim_o = IDX_W'(i);
    end
  end

  // R5
  one_oldest_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot(oldest));
  // R5
  touch_mru_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    touch_i |=> (age_q[$past(touch_idx_i)] == '0));
  // R5
  untouched_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !touch_i |=> $stable(age_q));
endmodule

// File: rtl/tlb.sv
module tlb
  import tlb_pkg::*;
#(
  parameter int unsigned ENTRIES = 16,
  parameter int unsigned VPN_W   = 20,
  parameter int unsigned PFN_W   = 16,
  parameter int unsigned OFF_W   = 12,
  localparam int unsigned IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1,
  localparam int unsigned PA_W   = PFN_W + OFF_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             flush_i,
  input  logic             lk_valid_i,
  input  logic [VPN_W-1:0] lk_vpn_i,
  input  logic [OFF_W-1:0] lk_off_i,
  output logic             lk_hit_o,
  output logic             lk_miss_o,
  output logic [PFN_W-1:0] lk_pfn_o,
  output logic [PA_W-1:0]  lk_paddr_o,
  input  logic             fill_i,
  input  logic [VPN_W-1:0] fill_vpn_i,
  input  logic [PFN_W-1:0] fill_pfn_i,
  input  logic             fill_pte_valid_i
);
  logic [ENTRIES-1:0]            vld_q;
  logic [ENTRIES-1:0][VPN_W-1:0] vpn_q;
  logic [ENTRIES-1:0][PFN_W-1:0] pfn_q;

  logic [ENTRIES-1:0] lk_match, fill_match;
  logic [IDX_W-1:0]   hit_idx, fmatch_idx, free_idx, victim, fill_tgt;
  logic               any_hit, do_fill, touch;
  logic [IDX_W-1:0]   touch_idx;
  fill_tgt_e          tgt_kind;

  tlb_cam #(.ENTRIES(ENTRIES), .VPN_W(VPN_W)) u_cam_lk (
    .valid_i(vld_q), .tag_i(vpn_q), .key_i(lk_vpn_i), .match_o(lk_match));

  tlb_cam #(.ENTRIES(ENTRIES), .VPN_W(VPN_W)) u_cam_fill (
    .valid_i(vld_q), .tag_i(vpn_q), .key_i(fill_vpn_i), .match_o(fill_match));

  always_comb begin
    hit_idx    = '0;
    fmatch_idx = '0;
    free_idx   = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (lk_match[i])   hit_idx    = IDX_W'(i);
      if (fill_match[i]) fmatch_idx = IDX_W'(i);
    end
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (!vld_q[i]) free_idx = IDX_W'(i);
    end
  end

  assign any_hit    = |lk_match;
  assign lk_hit_o   = lk_valid_i && any_hit;
  assign lk_miss_o  = lk_valid_i && !any_hit;
  assign lk_pfn_o   = lk_hit_o ? pfn_q[hit_idx] : '0;
  assign lk_paddr_o = {lk_pfn_o, lk_off_i};

  always_comb begin
    if (|fill_match)   tgt_kind = TGT_HIT;
    else if (!(&vld_q)) tgt_kind = TGT_FREE;
    else               tgt_kind = TGT_LRU;
    case (tgt_kind)
      TGT_HIT:  fill_tgt = fmatch_idx;
      TGT_FREE: fill_tgt = free_idx;
      default:  fill_tgt = victim;
    endcase
  end

  assign do_fill   = fill_i && !flush_i;
  assign touch     = do_fill || (lk_hit_o && !flush_i);
  assign touch_idx = fill_i ? fill_tgt : hit_idx;

  tlb_lru #(.ENTRIES(ENTRIES)) u_lru (
    .clk_i(clk_i), .rst_ni(rst_ni), .touch_i(touch),
    .touch_idx_i(touch_idx), .victim_o(victim));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q <= '0;
      vpn_q <= '0;
      pfn_q <= '0;
    end else if (flush_i) begin
      vld_q <= '0;
    end else if (do_fill) begin
      vld_q[fill_tgt] <= fill_pte_valid_i;
      vpn_q[fill_tgt] <= fill_vpn_i;
      pfn_q[fill_tgt] <= fill_pfn_i;
    end
  end

  // R9
  unique_tag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(lk_match) && $onehot0(fill_match));
  // R2
  hit_miss_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(lk_hit_o && lk_miss_o) && (lk_valid_i == (lk_hit_o || lk_miss_o)));
  // R7
  flush_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> (vld_q == '0));
  // R6
  fill_lands_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fill_i && !flush_i && fill_pte_valid_i) |=>
      (vld_q[$past(fill_tgt)] && (vpn_q[$past(fill_tgt)] == $past(fill_vpn_i))));
  // R4
  no_displace_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fill_i && !flush_i && !(|fill_match) && !(&vld_q)) |=>
      ((vld_q & $past(vld_q)) == $past(vld_q)));
endmodule

// File: tb/tb_tlb.sv
module tb_tlb;
  localparam int N     = 4;
  localparam int VPN_W = 4;
  localparam int PFN_W = 5;
  localparam int OFF_W = 3;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic flush_i = 1'b0, lk_valid_i = 1'b0, fill_i = 1'b0, fill_pte_valid_i = 1'b0;
  logic [VPN_W-1:0] lk_vpn_i = '0, fill_vpn_i = '0;
  logic [OFF_W-1:0] lk_off_i = '0;
  logic [PFN_W-1:0] fill_pfn_i = '0;
  logic lk_hit_o, lk_miss_o;
  logic [PFN_W-1:0] lk_pfn_o;
  logic [PFN_W+OFF_W-1:0] lk_paddr_o;

  always #4 clk = ~clk;

  tlb #(.ENTRIES(N), .VPN_W(VPN_W), .PFN_W(PFN_W), .OFF_W(OFF_W)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .flush_i(flush_i),
    .lk_valid_i(lk_valid_i), .lk_vpn_i(lk_vpn_i), .lk_off_i(lk_off_i),
    .lk_hit_o(lk_hit_o), .lk_miss_o(lk_miss_o), .lk_pfn_o(lk_pfn_o),
    .lk_paddr_o(lk_paddr_o), .fill_i(fill_i), .fill_vpn_i(fill_vpn_i),
    .fill_pfn_i(fill_pfn_i), .fill_pte_valid_i(fill_pte_valid_i));

  int vectors = 0, errors = 0;
  bit done = 0;

  // recency model: ord[0] most recent, ord[N-1] least recent
  bit m_vld[N];
  int m_vpn[N], m_pfn[N], m_ord[N];

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    vectors++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d @%0t", req, act, exp, $time);
    end
  endtask

  function automatic int m_find(input int vpn);
    for (int i = 0; i < N; i++) if (m_vld[i] && m_vpn[i] == vpn) return i;
    return -1;
  endfunction

  task automatic m_touch(input int k);
    int p = 0;
    for (int i = 0; i < N; i++) if (m_ord[i] == k) p = i;
    for (int i = p; i > 0; i--) m_ord[i] = m_ord[i-1];
    m_ord[0] = k;
  endtask

  task automatic idle();
    lk_valid_i = 0; fill_i = 0; flush_i = 0;
  endtask

  task automatic lookup(input int vpn, input int off, input string req);
    int k, exp_pa;
    @(negedge clk);
    idle();
    lk_valid_i = 1; lk_vpn_i = VPN_W'(vpn); lk_off_i = OFF_W'(off);
    #1;
    k = m_find(vpn);
    chk(lk_hit_o == (k >= 0), req, int'(lk_hit_o), int'(k >= 0));
    chk(lk_miss_o == (k < 0), req, int'(lk_miss_o), int'(k < 0));
    if (k >= 0) begin
      exp_pa = (m_pfn[k] << OFF_W) | off;
      chk(int'(lk_pfn_o) == m_pfn[k], req, int'(lk_pfn_o), m_pfn[k]);
      chk(int'(lk_paddr_o) == exp_pa, req, int'(lk_paddr_o), exp_pa);
    end
    @(posedge clk);
    if (k >= 0) m_touch(k);
  endtask

  task automatic fill(input int vpn, input int pfn, input bit pv);
    int k;
    @(negedge clk);
    idle();
    fill_i = 1; fill_vpn_i = VPN_W'(vpn); fill_pfn_i = PFN_W'(pfn); fill_pte_valid_i = pv;
    @(posedge clk);
    k = m_find(vpn);
    if (k < 0) for (int i = N - 1; i >= 0; i--) if (!m_vld[i]) k = i;
    if (k < 0) k = m_ord[N-1];
    m_vld[k] = pv; m_vpn[k] = vpn; m_pfn[k] = pfn;
    m_touch(k);
  endtask

  task automatic flush(input bit with_fill);
    @(negedge clk);
    idle();
    flush_i = 1;
    if (with_fill) begin
      fill_i = 1; fill_vpn_i = 4'd3; fill_pfn_i = 5'd9; fill_pte_valid_i = 1;
    end
    @(posedge clk);
    for (int i = 0; i < N; i++) m_vld[i] = 0;
  endtask

  task automatic sweep(input string req);
    for (int v = 0; v < 16; v++) lookup(v, v % 8, req);
  endtask

  initial begin
    #(8 * 150000);
    errors++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    logic [31:0] seed = 32'h1234_5678;
    for (int i = 0; i < N; i++) begin m_vld[i] = 0; m_vpn[i] = 0; m_pfn[i] = 0; m_ord[i] = i; end
    repeat (3) @(posedge clk);
    @(negedge clk) rst_ni = 1;

    sweep("R8");                                   // all miss after reset
    @(negedge clk); idle(); lk_valid_i = 0; lk_vpn_i = 0; #1;
    chk(!lk_hit_o && !lk_miss_o, "R2", int'({lk_hit_o, lk_miss_o}), 0);

    for (int v = 1; v <= 4; v++) fill(v, 10 + v, 1);
    sweep("R4");                                   // free slots filled, none displaced
    @(negedge clk); idle(); lk_valid_i = 0; lk_vpn_i = 4'd2; #1;
    chk(!lk_hit_o && !lk_miss_o, "R2", int'({lk_hit_o, lk_miss_o}), 0);

    lookup(1, 5, "R1");                            // hit refreshes slot of vpn 1
    fill(5, 20, 1);                                // evicts vpn 2
    lookup(2, 0, "R5");
    lookup(9, 0, "R5");                            // miss, order unchanged
    fill(6, 21, 1);                                // evicts vpn 3
    sweep("R5");

    fill(1, 30, 1);                                // duplicate overwrite (R9 uniqueness)
    sweep("R6");
    fill(5, 31, 1);
    fill(6, 7, 1);
    sweep("R6");

    fill(7, 2, 0);
    lookup(7, 1, "R3");
    fill(5, 3, 0);
    lookup(5, 1, "R3");
    sweep("R3");

    flush(1);                                      // fill same cycle must be dropped
    sweep("R7");
    for (int v = 8; v < 12; v++) fill(v, v, 1);
    sweep("R4");

    for (int n = 0; n < 2000; n++) begin
      int op, v;
      seed = seed * 32'd1664525 + 32'd1013904223;
      op = int'(seed[31:28]);
      v  = int'(seed[18:16]);
      if (op < 8)       lookup(v, int'(seed[22:20]), "R1");
      else if (op < 15) fill(v, int'(seed[12:8]), seed[5:3] != 3'd0);
      else              flush(0);
    end
    sweep("R5");

    @(negedge clk); idle();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule